// File: doc/BRIEF.md
# Fractional-Rate Timestamp Counter

This block keeps a 64-bit time value that advances at a programmable fraction of its reference clock. On every reference cycle a 32-bit step value (the addend) is summed into a 32-bit phase accumulator. Each carry out of that sum adds one to the time value. The effective tick rate is therefore addend / 2^32 times the reference frequency. A host can trim the rate while the counter runs by rewriting the addend, and the time value does not jump when it does.

A small word-addressed register port gives the host three operations:
- Change the addend.
- Take a coherent snapshot of the 64-bit time and read it back as two 32-bit words.
- Load a new 64-bit time with two word writes, which may come in either order.

The live time value is also driven on an output port, for logic that needs a timebase.

Top module: `ts_rate_clock`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the time value and the phase accumulator are 0 and no load half is pending. The addend reads back as 32'h8000_0000.
- R2: On every clock edge out of reset, the addend is added into the accumulator. When that addition carries out of bit 31, the time value increases by one at the same edge. With addend 32'h8000_0000 the time value rises by exactly 10 over any 20 cycles.
- R3: The time value advances at addend / 2^32 increments per cycle. With addend 32'hC000_0000 it rises by exactly 30 over any 40 cycles.
- R4: A write to address 0 replaces the addend, and the new value is used from the next cycle on. The write keeps the accumulator remainder and does not step the time value. A read of address 0 returns the addend.
- R5: A write to address 3 with bit 0 set copies the time value held before that edge into a snapshot. After that, address 1 reads the snapshot's upper word and address 2 reads its lower word, and both stay unchanged until the next snapshot, even while the live value rolls its low word.
- R6: Address 3 always reads 0. A write to address 3 with bit 0 clear takes no snapshot.
- R7: A write to address 1 stages the upper word and a write to address 2 stages the lower word. The time value is untouched until both halves are staged, in either order. At the edge of the second write it becomes {upper, lower} and counting resumes from there.
- R8: A load overrides a carry increment in the same cycle. A load leaves the accumulator remainder intact.
- R9: Writing the same half twice before the other half arrives replaces the staged word, and the later value is the one loaded.
- R10: Reads of addresses 1 and 2 return the snapshot, never the live value or a staged word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | 2 | Word address: 0 addend, 1 upper word, 2 lower word, 3 command |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| time_o | output | 64 | Live time value |

## Verification
Writes take effect at the clock edge that samples the strobe:
- The time value changes, or loads, at that same edge.
- A snapshot holds the pre-edge time from that edge on.
- A new addend first shapes the sum one cycle later.

Read data is combinational, so it is valid in the same cycle as the address. The bench drives inputs on falling edges. A behavioural model updates at every rising edge, and both the live time and the read data are compared with it 2 ns after each rising edge. The targeted checks sample at that same point, right after the edge that carries the write.

// File: rtl/ts_clk_pkg.sv
package ts_clk_pkg;

    typedef enum logic [1:0] {
        SEL_ADDEND = 2'd0,
        SEL_HI     = 2'd1,
        SEL_LO     = 2'd2,
        SEL_CMD    = 2'd3
    } reg_sel_e;

    localparam int          SNAP_BIT       = 0;
    localparam logic [31:0] ADDEND_DEFAULT = 32'h8000_0000;

endpackage

// File: rtl/ts_phase_acc.sv
module ts_phase_acc #(
    parameter int               ACC_W      = 32,
    parameter logic [ACC_W-1:0] ADDEND_RST = {1'b1, {(ACC_W-1){1'b0}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addend_we,
    input  logic [ACC_W-1:0] addend_wdata,
    output logic [ACC_W-1:0] addend_o,
    output logic             carry_o
);

    typedef struct packed {
        logic [ACC_W-1:0] addend;
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W:0] sum_w;

    always_comb begin
        st_d  = st_q;
        sum_w = {1'b0, st_q.acc} + {1'b0, st_q.addend};
        st_d.acc = sum_w[ACC_W-1:0];
        if (addend_we) begin
            st_d.addend = addend_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addend <= ADDEND_RST;
            st_q.acc    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addend_o = st_q.addend;
    assign carry_o  = sum_w[ACC_W];

endmodule

// File: rtl/ts_load_stage.sv
module ts_load_stage #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [WORD_W-1:0] wdata,
    output logic              commit_o,
    output logic [2*WORD_W-1:0] load_val_o
);

    typedef struct packed {
        logic              hi_pend;
        logic              lo_pend;
        logic [WORD_W-1:0] hi_word;
        logic [WORD_W-1:0] lo_word;
    } stage_state_t;

    stage_state_t st_d, st_q;
    logic         commit_w;

    always_comb begin
        st_d     = st_q;
        commit_w = (wr_hi && st_q.lo_pend) || (wr_lo && st_q.hi_pend);
        if (wr_hi) begin
            st_d.hi_word = wdata;
            st_d.hi_pend = 1'b1;
        end
        if (wr_lo) begin
            st_d.lo_word = wdata;
            st_d.lo_pend = 1'b1;
        end
        if (commit_w) begin
            st_d.hi_pend = 1'b0;
            st_d.lo_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o   = commit_w;
    assign load_val_o = {(wr_hi ? wdata : st_q.hi_word),
                         (wr_lo ? wdata : st_q.lo_word)};

endmodule

// File: rtl/ts_time_count.sv
module ts_time_count #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/ts_rate_clock.sv
module ts_rate_clock #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 32,
    parameter logic [ACC_W-1:0] ADDEND_RST = {1'b1, {(ACC_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [2*DATA_W-1:0] time_o
);
    import ts_clk_pkg::*;

    localparam int CNT_W  = 2 * DATA_W;
    localparam int NWORDS = CNT_W / DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] snap;
    } top_state_t;

    top_state_t st_d, st_q;

    logic               wr_addend, wr_hi, wr_lo, snap_req;
    logic [ACC_W-1:0]   addend_w;
    logic               carry_w;
    logic               stage_commit;
    logic [CNT_W-1:0]   stage_val;
    logic [CNT_W-1:0]   cnt_w;
    logic [CNT_W-1:0]   snap_now;
    logic [DATA_W-1:0]  snap_word [NWORDS];

    always_comb begin
        wr_addend = reg_wr && (reg_sel_e'(reg_addr) == SEL_ADDEND);
        wr_hi     = reg_wr && (reg_sel_e'(reg_addr) == SEL_HI);
        wr_lo     = reg_wr && (reg_sel_e'(reg_addr) == SEL_LO);
        snap_req  = reg_wr && (reg_sel_e'(reg_addr) == SEL_CMD) && reg_wdata[SNAP_BIT];
    end

    ts_phase_acc #(
        .ACC_W      (ACC_W),
        .ADDEND_RST (ADDEND_RST)
    ) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .addend_we    (wr_addend),
        .addend_wdata (reg_wdata[ACC_W-1:0]),
        .addend_o     (addend_w),
        .carry_o      (carry_w)
    );

    ts_load_stage #(
        .WORD_W (DATA_W)
    ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hi      (wr_hi),
        .wr_lo      (wr_lo),
        .wdata      (reg_wdata),
        .commit_o   (stage_commit),
        .load_val_o (stage_val)
    );

    ts_time_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (carry_w),
        .load     (stage_commit),
        .load_val (stage_val),
        .cnt_o    (cnt_w)
    );

    always_comb begin
        st_d = st_q;
        if (snap_req) begin
            st_d.snap = cnt_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_now = st_q.snap;

    for (genvar g = 0; g < NWORDS; g++) begin : g_snap_word
        assign snap_word[g] = st_q.snap[g*DATA_W +: DATA_W];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_addr))
            SEL_ADDEND: reg_rdata = DATA_W'(addend_w);
            SEL_HI:     reg_rdata = snap_word[NWORDS-1];
            SEL_LO:     reg_rdata = snap_word[0];
            default:    reg_rdata = '0;
        endcase
    end

    assign time_o = cnt_w;

endmodule

module ts_rate_clock_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          reg_addr,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic [2*DATA_W-1:0] time_o,
    input logic                commit,
    input logic [2*DATA_W-1:0] load_val,
    input logic                snap_req,
    input logic [2*DATA_W-1:0] snap
);
    import ts_clk_pkg::*;

    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (time_o == $past(time_o) || time_o == $past(time_o) + 1'b1)); // R2

    AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (time_o == $past(load_val))); // R7

    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (snap == $past(time_o))); // R5

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(snap)); // R5

    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_e'(reg_addr) == SEL_CMD) |-> (reg_rdata == '0)); // R6

endmodule

bind ts_rate_clock ts_rate_clock_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .time_o    (time_o),
    .commit    (stage_commit),
    .load_val  (stage_val),
    .snap_req  (snap_req),
    .snap      (snap_now)
);

// File: tb/sim_ts_rate_clock.sv
module sim_ts_rate_clock;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] time_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ts_rate_clock u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .time_o    (time_o)
    );

    // behavioural reference model
    longint unsigned m_cnt;
    longint unsigned m_snap;
    bit [31:0] m_acc, m_add, m_hi, m_lo;
    bit        m_hp, m_lp;

    always @(posedge clk) begin
        bit [32:0] s;
        bit        ld;
        longint unsigned nv;
        if (!rst_n) begin
            m_cnt = 0; m_snap = 0; m_acc = 0; m_add = 32'h8000_0000;
            m_hi = 0; m_lo = 0; m_hp = 0; m_lp = 0;
        end else begin
            s  = {1'b0, m_acc} + {1'b0, m_add};
            ld = 0;
            nv = 0;
            if (reg_wr && reg_addr == 2'd3 && reg_wdata[0]) m_snap = m_cnt;
            if (reg_wr && reg_addr == 2'd1) begin
                m_hi = reg_wdata;
                if (m_lp) begin ld = 1; nv = {reg_wdata, m_lo}; end
                m_hp = 1;
            end
            if (reg_wr && reg_addr == 2'd2) begin
                m_lo = reg_wdata;
                if (m_hp) begin ld = 1; nv = {m_hi, reg_wdata}; end
                m_lp = 1;
            end
            if (ld) begin m_hp = 0; m_lp = 0; end
            m_cnt = ld ? nv : m_cnt + longint'(s[32]);
            m_acc = s[31:0];
            if (reg_wr && reg_addr == 2'd0) m_add = reg_wdata;
        end
    end

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_add;
            2'd1: return m_snap[63:32];
            2'd2: return m_snap[31:0];
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(time_o == m_cnt, "R2 live time vs model", time_o, m_cnt);
            chk(reg_rdata == model_read(reg_addr), "R5 read data vs model",
                {32'd0, reg_rdata}, {32'd0, model_read(reg_addr)});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        logic [63:0] t0;
        repeat (4) @(posedge clk);
        #2;
        chk(time_o == 64'd0, "R1 time zero in reset", time_o, 64'd0);
        chk(reg_rdata == 32'h8000_0000, "R1 addend reset value", {32'd0, reg_rdata}, 64'h8000_0000);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: half rate
        @(posedge clk); #2;
        t0 = time_o;
        repeat (20) @(posedge clk);
        #2;
        chk(time_o == t0 + 64'd10, "R2 ten ticks in twenty cycles", time_o, t0 + 64'd10);

        // R3 and R4: addend 0xC0000000
        wr(2'd0, 32'hC000_0000);
        rd(2'd0, v);
        chk(v == 32'hC000_0000, "R4 addend readback", {32'd0, v}, 64'h C000_0000);
        @(posedge clk); #2;
        t0 = time_o;
        repeat (40) @(posedge clk);
        #2;
        chk(time_o == t0 + 64'd30, "R3 thirty ticks in forty cycles", time_o, t0 + 64'd30);
        wr(2'd0, 32'h8000_0000);

        // R7: high first, then snapshot near low-word rollover (R5)
        wr(2'd1, 32'h0000_0001);
        wr(2'd2, 32'hFFFF_FFFE);
        #1;
        chk(time_o == 64'h1_FFFF_FFFE, "R7 load high then low", time_o, 64'h1_FFFF_FFFE);
        wr(2'd3, 32'd1);
        repeat (12) @(posedge clk);
        #2;
        chk(time_o > 64'h2_0000_0000, "R5 live low word rolled", time_o, 64'h2_0000_0001);
        rd(2'd1, v);
        rd(2'd2, v2);
        chk(v == 32'd1, "R5 snapshot upper word", {32'd0, v}, 64'd1);
        chk(v2 == 32'hFFFF_FFFE, "R5 snapshot lower word", {32'd0, v2}, 64'hFFFF_FFFE);

        // R6: command reads zero, clear bit takes no snapshot
        rd(2'd3, v);
        chk(v == 32'd0, "R6 command reads zero", {32'd0, v}, 64'd0);
        wr(2'd3, 32'd0);
        rd(2'd2, v);
        chk(v == 32'hFFFF_FFFE, "R6 no snapshot with bit clear", {32'd0, v}, 64'hFFFF_FFFE);

        // R7 low first; R10 staged word not visible
        wr(2'd2, 32'h1234_5678);
        repeat (3) @(posedge clk);
        #2;
        chk(time_o[63:32] == 32'd2, "R7 no load after one half", time_o, 64'h2_0000_0000);
        rd(2'd2, v);
        chk(v == 32'hFFFF_FFFE, "R10 read returns snapshot not staged", {32'd0, v}, 64'hFFFF_FFFE);
        wr(2'd1, 32'h0000_ABCD);
        #1;
        chk(time_o == 64'h0000_ABCD_1234_5678, "R7 load low then high", time_o, 64'h0000_ABCD_1234_5678);

        // R9: repeated high write replaces staged value; R8 load is exact despite carry phase
        wr(2'd1, 32'h1111_1111);
        wr(2'd1, 32'h2222_2222);
        wr(2'd2, 32'h3333_3333);
        #1;
        chk(time_o == 64'h2222_2222_3333_3333, "R9 later staged half wins", time_o, 64'h2222_2222_3333_3333);
        wr(2'd1, 32'h0);
        @(negedge clk);
        wr(2'd2, 32'h10);
        #1;
        chk(time_o == 64'h10, "R8 load overrides carry", time_o, 64'h10);
        repeat (10) @(posedge clk);
        #2;
        chk(time_o == 64'h15, "R8 accumulator phase kept after load", time_o, 64'h15);

        repeat (4) @(posedge clk);
        #3;
        finish_run();
    end

endmodule